// File: doc/BRIEF.md
# Three-Vector-Testable Ripple-Carry Adder

This block adds two unsigned operands and a carry-in with a plain serial carry chain. Each bit position is one full-adder cell made of five two-input gates, all of them NOR or XNOR (equivalence). The cell equations are picked so that three fixed input vectors, applied to the whole word, expose any single stuck-at fault on any gate pin or cell input stem. The sum bit of a cell is the equivalence chain of its two operand bits and its incoming carry. The carry-out is the equivalence of "a or b" with "carry-in or (a equivalent b)". The two OR terms are taken from NOR outputs, whose inversions cancel inside the XNOR.

The gates are separate instances so that a testbench can force any single net to 0 or 1 through a site index. The parameter `INJECT` removes all the force logic when set to 0. Every cell owns 18 consecutive fault sites. The three-vector test reaches every position at once because each vector sends into the next bit the same carry value that the vector applies at bit 0.

Top module: `tnx_adder`

## Requirements
- R1: With `inj_en`=0, `{cout,sum}` equals `a + b + cin` for every operand pair and carry-in.
- R2: Sum bit i equals a[i] XOR b[i] XOR the carry entering bit i.
- R3: The carry leaving a cell equals (a OR b) XNOR (carry-in OR (a XNOR b)), which is the majority of the three cell inputs.
- R4: `cin` enters bit 0, the carry out of bit i enters bit i+1, and `cout` is the carry out of the top bit. With a all ones, b zero and cin=1, the carry travels the whole word.
- R5: Test vector 1 is cin=0, a=0, b=all ones. The response is sum=all ones and cout=0.
- R6: Test vector 2 is all inputs zero. The response is sum=0 and cout=0.
- R7: Test vector 3 is cin=1, a=all ones, b=0. The response is sum=0 and cout=1.
- R8: With `inj_en`=1, fault site `inj_site` is held at `inj_val`. Cell i owns sites 18i to 18i+17. Offsets 0, 1 and 2 are the stems of a[i], b[i] and the incoming carry. Offset 3+3k+p is pin p (0 = first input, 1 = second input, 2 = output) of gate k. The gates are numbered: k=0 NOR(a,b), k=1 XNOR(a,b), k=2 NOR(carry-in, gate 1), k=3 carry XNOR(gate 0, gate 2), k=4 sum XNOR(gate 1, carry-in).
- R9: Every single stuck-at-0 or stuck-at-1 fault on every site makes at least one output differ from the R5/R6/R7 responses on at least one of the three vectors.
- R10: With `inj_en`=0, the values of `inj_site` and `inj_val` have no effect on the outputs.
- R11: A site index at or above 18·WIDTH has no effect, even with `inj_en`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| inj_en | input | 1 | Fault force enable (test use) |
| inj_val | input | 1 | Value forced on the selected site |
| inj_site | input | SITE_W | Index of the fault site to force |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
Every operand pair and carry-in of a 6-bit instance is applied with forcing disabled and the site and value inputs scrambled. This separates arithmetic errors from any leak of the inactive force path. Single-bit carry cases with the upper bits zero isolate the carry rule of bit 0. The full-propagate pattern separates a broken chain link from a local cell error. Each of the 216 single faults is then run through the three test vectors and must be caught. A few forced sites with exactly predicted outputs, and out-of-range site indices, confirm the site numbering.

// File: rtl/tnx_pkg.sv
package tnx_pkg;

    // Fault-site bookkeeping
    localparam int FSITE_W        = 16;
    localparam int STEMS_PER_CELL = 3;
    localparam int GATES_PER_CELL = 5;
    localparam int PINS_PER_GATE  = 3;
    localparam int SITES_PER_CELL = STEMS_PER_CELL + GATES_PER_CELL * PINS_PER_GATE;

    // Stem offsets inside a cell
    localparam int STEM_A  = 0;
    localparam int STEM_B  = 1;
    localparam int STEM_CI = 2;

    // Gate slots inside a cell
    localparam int SLOT_NOR_AB = 0;
    localparam int SLOT_EQ_AB  = 1;
    localparam int SLOT_NOR_CX = 2;
    localparam int SLOT_CARRY  = 3;
    localparam int SLOT_SUM    = 4;

    // Pin offsets inside a gate
    localparam int PIN_IN0 = 0;
    localparam int PIN_IN1 = 1;
    localparam int PIN_OUT = 2;

    typedef logic [FSITE_W-1:0] site_t;

    typedef enum logic {
        GK_NOR,
        GK_XNOR
    } gate_kind_e;

    typedef struct packed {
        logic  en;
        logic  val;
        site_t site;
    } fault_cmd_t;

    function automatic int gate_site(input int cell_base, input int slot, input int pin);
        return cell_base + STEMS_PER_CELL + slot * PINS_PER_GATE + pin;
    endfunction

    function automatic int total_sites(input int width);
        return width * SITES_PER_CELL;
    endfunction

    // Replace a net value by the forced value when its site is selected
    function automatic logic tap(input logic v, input fault_cmd_t fc, input int idx);
        return (fc.en && (fc.site == site_t'(idx))) ? fc.val : v;
    endfunction

endpackage

// File: rtl/tnx_stem.sv
module tnx_stem
    import tnx_pkg::*;
#(
    parameter int SITE   = 0,
    parameter bit INJECT = 1'b1
) (
    input  logic       d,
    input  fault_cmd_t fc,
    output logic       q
);

    generate
        if (INJECT) begin : g_tap
            assign q = tap(d, fc, SITE);
        end else begin : g_plain
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/tnx_gate2.sv
module tnx_gate2
    import tnx_pkg::*;
#(
    parameter gate_kind_e KIND   = GK_NOR,
    parameter int         BASE   = 0,
    parameter bit         INJECT = 1'b1
) (
    input  logic       x0,
    input  logic       x1,
    input  fault_cmd_t fc,
    output logic       z
);

    logic p0, p1, raw;

    generate
        if (INJECT) begin : g_tap_in
            assign p0 = tap(x0, fc, BASE + PIN_IN0);
            assign p1 = tap(x1, fc, BASE + PIN_IN1);
        end else begin : g_plain_in
            assign p0 = x0;
            assign p1 = x1;
        end

        if (KIND == GK_NOR) begin : g_nor
            assign raw = ~(p0 | p1);
        end else begin : g_xnor
            assign raw = ~(p0 ^ p1);
        end

        if (INJECT) begin : g_tap_out
            assign z = tap(raw, fc, BASE + PIN_OUT);
        end else begin : g_plain_out
            assign z = raw;
        end
    endgenerate

endmodule

// File: rtl/tnx_cell.sv
module tnx_cell
    import tnx_pkg::*;
#(
    parameter int BASE   = 0,
    parameter bit INJECT = 1'b1
) (
    input  logic       a,
    input  logic       b,
    input  logic       ci,
    input  fault_cmd_t fc,
    output logic       s,
    output logic       co
);

    logic a_t, b_t, c_t;
    logic nor_ab, eq_ab, nor_cx;

    tnx_stem #(.SITE(BASE + STEM_A),  .INJECT(INJECT)) u_stem_a (.d(a),  .fc(fc), .q(a_t));
    tnx_stem #(.SITE(BASE + STEM_B),  .INJECT(INJECT)) u_stem_b (.d(b),  .fc(fc), .q(b_t));
    tnx_stem #(.SITE(BASE + STEM_CI), .INJECT(INJECT)) u_stem_c (.d(ci), .fc(fc), .q(c_t));

    // not(a or b)
    tnx_gate2 #(.KIND(GK_NOR), .BASE(gate_site(BASE, SLOT_NOR_AB, 0)), .INJECT(INJECT))
        u_nor_ab (.x0(a_t), .x1(b_t), .fc(fc), .z(nor_ab));

    // a equivalent b
    tnx_gate2 #(.KIND(GK_XNOR), .BASE(gate_site(BASE, SLOT_EQ_AB, 0)), .INJECT(INJECT))
        u_eq_ab (.x0(a_t), .x1(b_t), .fc(fc), .z(eq_ab));

    // not(ci or (a equivalent b))
    tnx_gate2 #(.KIND(GK_NOR), .BASE(gate_site(BASE, SLOT_NOR_CX, 0)), .INJECT(INJECT))
        u_nor_cx (.x0(c_t), .x1(eq_ab), .fc(fc), .z(nor_cx));

    // carry: the two inversions cancel inside the equivalence
    tnx_gate2 #(.KIND(GK_XNOR), .BASE(gate_site(BASE, SLOT_CARRY, 0)), .INJECT(INJECT))
        u_carry (.x0(nor_ab), .x1(nor_cx), .fc(fc), .z(co));

    // sum: equivalence chain of a, b, ci
    tnx_gate2 #(.KIND(GK_XNOR), .BASE(gate_site(BASE, SLOT_SUM, 0)), .INJECT(INJECT))
        u_sum (.x0(eq_ab), .x1(c_t), .fc(fc), .z(s));

endmodule

// File: rtl/tnx_adder.sv
module tnx_adder
    import tnx_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit INJECT  = 1'b1,
    localparam int N_SITES = total_sites(WIDTH),
    localparam int SITE_W  = $clog2(N_SITES)
) (
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  logic              cin,
    input  logic              inj_en,
    input  logic              inj_val,
    input  logic [SITE_W-1:0] inj_site,
    output logic [WIDTH-1:0]  sum,
    output logic              cout
);

    fault_cmd_t cmd;
    logic [WIDTH:0] c;

    assign cmd.en   = inj_en;
    assign cmd.val  = inj_val;
    assign cmd.site = site_t'(inj_site);

    assign c[0] = cin;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            tnx_cell #(.BASE(i * SITES_PER_CELL), .INJECT(INJECT)) u_cell (
                .a  (a[i]),
                .b  (b[i]),
                .ci (c[i]),
                .fc (cmd),
                .s  (sum[i]),
                .co (c[i+1])
            );
        end
    endgenerate

    assign cout = c[WIDTH];

endmodule

// File: rtl/tnx_adder_chk.sv
module tnx_adder_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic             inj_en,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [WIDTH:0]   carry
);

    logic [WIDTH:0] total;
    assign total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        if (!inj_en && !$isunknown({a, b, cin})) begin
            p_total_r1: assert ({cout, sum} == total)
                else $error("arithmetic result differs from operand sum");
            for (int i = 0; i < WIDTH; i++) begin
                p_bit_sum_r2: assert (sum[i] == (a[i] ^ b[i] ^ carry[i]))
                    else $error("sum bit %0d inconsistent with its carry", i);
                p_carry_maj_r3: assert (carry[i+1] ==
                        ((a[i] & b[i]) | (carry[i] & (a[i] | b[i]))))
                    else $error("carry out of bit %0d is not the majority", i);
            end
            if (!cin && a == '0 && b == '1) begin
                p_vec1_r5: assert (sum == '1 && !cout)
                    else $error("test vector 1 response wrong");
            end
            if (!cin && a == '0 && b == '0) begin
                p_vec2_r6: assert (sum == '0 && !cout)
                    else $error("test vector 2 response wrong");
            end
            if (cin && a == '1 && b == '0) begin
                p_vec3_r7: assert (sum == '0 && cout)
                    else $error("test vector 3 response wrong");
            end
        end
    end

endmodule

bind tnx_adder tnx_adder_chk #(.WIDTH(WIDTH)) i_tnx_adder_chk (
    .a      (a),
    .b      (b),
    .cin    (cin),
    .inj_en (inj_en),
    .sum    (sum),
    .cout   (cout),
    .carry  (c)
);

// File: tb/test_tnx_adder.sv
module test_tnx_adder;

    localparam int WIDTH = 6;
    localparam int SITES = WIDTH * 18;
    localparam int SW    = $clog2(SITES);
    localparam logic [WIDTH-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [WIDTH-1:0] a = '0;
    logic [WIDTH-1:0] b = '0;
    logic             cin = 1'b0;
    logic             inj_en = 1'b0;
    logic             inj_val = 1'b0;
    logic [SW-1:0]    inj_site = '0;
    logic [WIDTH-1:0] sum;
    logic             cout;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    tnx_adder #(.WIDTH(WIDTH)) i_tnx_adder (
        .a        (a),
        .b        (b),
        .cin      (cin),
        .inj_en   (inj_en),
        .inj_val  (inj_val),
        .inj_site (inj_site),
        .sum      (sum),
        .cout     (cout)
    );

    task automatic drive(input logic [WIDTH-1:0] ta, input logic [WIDTH-1:0] tb, input logic tc);
        @(posedge clk);
        #1;
        a   = ta;
        b   = tb;
        cin = tc;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [WIDTH:0] exp);
        n_chk++;
        if ({cout, sum} !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, {cout, sum}, exp);
        end
    endtask

    task automatic force_site(input int site, input logic v);
        inj_en   = 1'b1;
        inj_site = SW'(site);
        inj_val  = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R6: idle / all-zero vector after reset
        drive('0, '0, 1'b0);
        expect_out("R6 idle zeros", '0);

        // R1, R10: exhaustive sweep, force path disabled but scrambled
        for (int ia = 0; ia < (1 << WIDTH); ia++) begin
            for (int ib = 0; ib < (1 << WIDTH); ib++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    inj_en   = 1'b0;
                    inj_site = SW'((ia * 5 + ib * 3 + ic) % (1 << SW));
                    inj_val  = logic'((ia ^ ib) & 1);
                    drive(WIDTH'(ia), WIDTH'(ib), logic'(ic));
                    expect_out("R1/R10 add", (WIDTH + 1)'(ia + ib + ic));
                end
            end
        end

        // R2, R3: carry out of bit 0 seen on sum[1]
        for (int k = 0; k < 8; k++) begin
            logic ca, cb, cc, maj;
            ca  = logic'(k & 1);
            cb  = logic'((k >> 1) & 1);
            cc  = logic'((k >> 2) & 1);
            maj = (ca & cb) | (cc & (ca | cb));
            drive({{(WIDTH-1){1'b0}}, ca}, {{(WIDTH-1){1'b0}}, cb}, cc);
            expect_out("R3 carry rule / R2 bit sum",
                       {1'b0, {(WIDTH-2){1'b0}}, maj, ca ^ cb ^ cc});
        end

        // R4: full propagation through every link
        drive(ONES, '0, 1'b1);
        expect_out("R4 chain propagate", (WIDTH + 1)'(1 << WIDTH));
        drive(ONES, {{(WIDTH-1){1'b0}}, 1'b1}, 1'b0);
        expect_out("R4 chain from bit 0", (WIDTH + 1)'(1 << WIDTH));

        // R5, R6, R7: the three test vectors
        drive('0, ONES, 1'b0);
        expect_out("R5 vector 1", {1'b0, ONES});
        drive('0, '0, 1'b0);
        expect_out("R6 vector 2", '0);
        drive(ONES, '0, 1'b1);
        expect_out("R7 vector 3", (WIDTH + 1)'(1 << WIDTH));

        // R8: site numbering
        force_site(17, 1'b1);             // cell 0 sum gate output
        drive('0, '0, 1'b0);
        expect_out("R8 cell0 sum out sa1", (WIDTH + 1)'(1));
        force_site(36, 1'b1);             // cell 2 stem of a
        drive('0, '0, 1'b0);
        expect_out("R8 cell2 a stem sa1", (WIDTH + 1)'(4));
        force_site(32, 1'b1);             // cell 1 carry gate output
        drive('0, '0, 1'b0);
        expect_out("R8 cell1 carry out sa1", (WIDTH + 1)'(4));
        drive(ONES, ONES, 1'b0);
        expect_out("R8 stuck at active value", (WIDTH + 1)'(2 * ((1 << WIDTH) - 1)));

        // R11: out-of-range sites
        for (int s = SITES; s < (1 << SW); s++) begin
            force_site(s, 1'b1);
            drive('0, '0, 1'b0);
            expect_out("R11 high site sa1", '0);
            force_site(s, 1'b0);
            drive(ONES, '0, 1'b1);
            expect_out("R11 high site sa0", (WIDTH + 1)'(1 << WIDTH));
        end

        // R9: every single stuck-at fault caught by the three vectors
        for (int s = 0; s < SITES; s++) begin
            for (int v = 0; v < 2; v++) begin
                logic hit;
                hit = 1'b0;
                force_site(s, logic'(v));
                drive('0, ONES, 1'b0);
                if ({cout, sum} !== {1'b0, ONES}) hit = 1'b1;
                drive('0, '0, 1'b0);
                if ({cout, sum} !== '0) hit = 1'b1;
                drive(ONES, '0, 1'b1);
                if ({cout, sum} !== (WIDTH + 1)'(1 << WIDTH)) hit = 1'b1;
                n_chk++;
                if (!hit) begin
                    n_bad++;
                    $display("FAIL R9 site %0d stuck-at-%0d: got detected=0 expected detected=1", s, v);
                end
            end
        end

        inj_en = 1'b0;
        done   = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule